// File: doc/BRIEF.md
# Bus Idle Cycle Insertion Controller

This block sits between a bus master's access requests and the bus cycle sequencer that runs them. For each accepted access it works out how many idle bus cycles must go between the previous access and this one. It then holds the access back for that many cycles before it is issued. Idle time is needed in only two cases: when the bus moves from one address space to another, and when a read in a space is followed by a write to the same space. The count always comes from a 3-bit field that belongs to the space the bus is leaving.

A single 32-bit configuration word holds one count field for each of seven external memory areas and one for the acknowledge-driven DMA device. The device field applies only while that device takes part in a single-address DMA transfer. Dual-address transfers move between ordinary areas and therefore use the area fields. A requester offers one access at a time with a valid/ready handshake. The block issues each access as a one-cycle pulse carrying the access attributes.

Top module: `bus_idle_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x77777777, so every count field holds 7.
- R2: Area n (0 to 6) keeps its count in bits 4n+2..4n and the DMA device keeps its count in bits 30..28. A write stores only these bits. Bits 3, 7, 11, 15, 19, 23, 27 and 31 always read 0. The word does not change while no write is made.
- R3: The first access accepted after reset is issued with no idle cycles.
- R4: When an access targets a different area code than the previous access, v idle cycles are inserted, where v is the field of the area being left. The access is issued exactly 1+v cycles after the accepting clock edge.
- R5: A write that follows a read with the same area code inserts the field of that area.
- R6: Two reads, two writes, or a write followed by a read, all with the same area code, insert no idle cycles.
- R7: Area code 7 is the DMA device. When the previous access used code 7 with the single-address flag set, either leaving the device or a read followed by a write on it inserts the count in bits 30..28.
- R8: In dual-address transfers (single-address flag clear), the area fields apply as for any other access. Leaving code 7 with the flag clear inserts no idle cycles.
- R9: A field value of 0 gives no gap: the access is issued on the cycle after acceptance.
- R10: A configuration write affects only decisions made at later clock edges. A countdown already running completes with the count it started with.
- R11: The ready output is low during every inserted idle cycle and high otherwise. Each accepted access is issued exactly once, as a one-cycle pulse, in acceptance order and with its own area, direction and single-address flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word, reserved bits zero |
| req_valid | input | 1 | Access request present |
| req_area | input | 3 | Target area code, 7 = DMA device |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma_single | input | 1 | Access belongs to a single-address DMA transfer |
| req_ready | output | 1 | Request accepted on a clock edge where valid and ready are both high |
| iss_valid | output | 1 | One-cycle pulse: start this bus cycle now |
| iss_area | output | 3 | Area code of the issued access |
| iss_write | output | 1 | Direction of the issued access |
| iss_dma_single | output | 1 | Single-address flag of the issued access |

## Verification
If the recorded previous space or direction is wrong, the error shows on the next accepted access. That access gets a gap of the wrong length, so its issue pulse arrives in the wrong cycle and ready stays low for the wrong number of cycles. If the countdown counter is wrong, the issue time of the access already waiting moves. An error in a stored field shows at once on the configuration read port, and on the first access that leaves the affected space. Every issue pulse is compared to a predicted cycle, so any timing error is reported within eight cycles of the access that caused it.

// File: rtl/bic_pkg.sv
package bic_pkg;

  // Stall sequencer phases
  typedef enum logic {
    ST_OPEN  = 1'b0,   // accepting requests
    ST_COUNT = 1'b1    // counting down inserted idle cycles
  } bic_state_e;

endpackage

// File: rtl/bic_cfg_regs.sv
module bic_cfg_regs #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned FIELD_W   = 3,
  parameter int unsigned SLOT_W    = 4,
  localparam int unsigned REG_W    = NUM_SLOTS * SLOT_W,
  localparam int unsigned FLAT_W   = NUM_SLOTS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [FLAT_W-1:0] fields
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [FIELD_W-1:0] val;

    always_ff @(posedge clk) begin
      if (rst)     val <= '1;
      else if (we) val <= wdata[s*SLOT_W +: FIELD_W];
    end

    assign fields[s*FIELD_W +: FIELD_W] = val;
    assign rdata[s*SLOT_W +: FIELD_W]   = val;
    if (SLOT_W > FIELD_W) begin : g_pad
      assign rdata[s*SLOT_W + FIELD_W +: (SLOT_W - FIELD_W)] = '0;
    end
  end

  // R2: the word keeps its value while no write is made
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));

endmodule

// File: rtl/bic_idle_pick.sv
module bic_idle_pick #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned FIELD_W   = 3,
  parameter int unsigned AREA_W    = 3,
  localparam int unsigned FLAT_W   = NUM_SLOTS * FIELD_W,
  localparam int unsigned DEV_CODE = NUM_SLOTS - 1
) (
  input  logic [FLAT_W-1:0]  fields,
  input  logic               prev_valid,
  input  logic [AREA_W-1:0]  prev_area,
  input  logic               prev_write,
  input  logic               prev_single,
  input  logic [AREA_W-1:0]  req_area,
  input  logic               req_write,
  output logic [FIELD_W-1:0] idle_cnt
);

  logic [FIELD_W-1:0] slot_val [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_unpack
    assign slot_val[s] = fields[s*FIELD_W +: FIELD_W];
  end

  logic space_change, turnaround, leave_dev, trigger;
  logic [FIELD_W-1:0] leave_val;

  always_comb begin
    space_change = (req_area != prev_area);
    turnaround   = (req_area == prev_area) && !prev_write && req_write;
    trigger      = prev_valid && (space_change || turnaround);
    leave_dev    = (prev_area == AREA_W'(DEV_CODE));
    if (leave_dev) leave_val = prev_single ? slot_val[DEV_CODE] : '0;
    else           leave_val = slot_val[prev_area];
    idle_cnt     = trigger ? leave_val : '0;
  end

endmodule

// File: rtl/bic_stall_seq.sv
module bic_stall_seq
  import bic_pkg::*;
#(
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned AREA_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [AREA_W-1:0]  req_area,
  input  logic               req_write,
  input  logic               req_single,
  input  logic [FIELD_W-1:0] idle_cnt,
  output logic               req_ready,
  output logic               iss_valid,
  output logic [AREA_W-1:0]  iss_area,
  output logic               iss_write,
  output logic               iss_single,
  output logic               prev_valid,
  output logic [AREA_W-1:0]  prev_area,
  output logic               prev_write,
  output logic               prev_single
);

  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  bic_state_e         st;
  logic [FIELD_W-1:0] cnt;
  logic               accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_OPEN;
      cnt         <= '0;
      req_ready   <= 1'b1;
      iss_valid   <= 1'b0;
      iss_area    <= '0;
      iss_write   <= 1'b0;
      iss_single  <= 1'b0;
      prev_valid  <= 1'b0;
      prev_area   <= '0;
      prev_write  <= 1'b0;
      prev_single <= 1'b0;
    end else begin
      iss_valid <= 1'b0;
      case (st)
        ST_OPEN: begin
          if (accept) begin
            prev_valid  <= 1'b1;
            prev_area   <= req_area;
            prev_write  <= req_write;
            prev_single <= req_single;
            iss_area    <= req_area;
            iss_write   <= req_write;
            iss_single  <= req_single;
            if (idle_cnt == '0) begin
              iss_valid <= 1'b1;
            end else begin
              st        <= ST_COUNT;
              cnt       <= idle_cnt;
              req_ready <= 1'b0;
            end
          end
        end
        ST_COUNT: begin
          if (cnt == ONE) begin
            st        <= ST_OPEN;
            req_ready <= 1'b1;
            iss_valid <= 1'b1;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: st <= ST_OPEN;
      endcase
    end
  end

  // R11: no request is taken while idle cycles are being counted
  assert_ready_low_counting_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT) |-> !req_ready);

  // R4 / R10: the countdown steps by one per cycle, whatever the configuration does
  assert_countdown_step_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && cnt > ONE) |=> (st == ST_COUNT && cnt == $past(cnt) - ONE));

  // R9: a zero count issues on the next cycle
  assert_zero_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && idle_cnt == '0) |=> iss_valid);

  // R11: an issue pulse follows either an acceptance or the end of a countdown
  assert_issue_source_R11: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> ($past(accept) || $past(st == ST_COUNT)));

endmodule

// File: rtl/bus_idle_ctrl.sv
module bus_idle_ctrl #(
  parameter int unsigned NUM_AREAS = 7,
  parameter int unsigned FIELD_W   = 3,
  parameter int unsigned SLOT_W    = 4,
  localparam int unsigned NUM_SLOTS = NUM_AREAS + 1,
  localparam int unsigned REG_W     = NUM_SLOTS * SLOT_W,
  localparam int unsigned AREA_W    = $clog2(NUM_SLOTS),
  localparam int unsigned FLAT_W    = NUM_SLOTS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              req_dma_single,
  output logic              req_ready,
  output logic              iss_valid,
  output logic [AREA_W-1:0] iss_area,
  output logic              iss_write,
  output logic              iss_dma_single
);

  logic [FLAT_W-1:0]  fields;
  logic [FIELD_W-1:0] idle_cnt;
  logic               prev_valid, prev_write, prev_single;
  logic [AREA_W-1:0]  prev_area;

  bic_cfg_regs #(
    .NUM_SLOTS (NUM_SLOTS),
    .FIELD_W   (FIELD_W),
    .SLOT_W    (SLOT_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .fields (fields)
  );

  bic_idle_pick #(
    .NUM_SLOTS (NUM_SLOTS),
    .FIELD_W   (FIELD_W),
    .AREA_W    (AREA_W)
  ) u_pick (
    .fields      (fields),
    .prev_valid  (prev_valid),
    .prev_area   (prev_area),
    .prev_write  (prev_write),
    .prev_single (prev_single),
    .req_area    (req_area),
    .req_write   (req_write),
    .idle_cnt    (idle_cnt)
  );

  bic_stall_seq #(
    .FIELD_W (FIELD_W),
    .AREA_W  (AREA_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_area    (req_area),
    .req_write   (req_write),
    .req_single  (req_dma_single),
    .idle_cnt    (idle_cnt),
    .req_ready   (req_ready),
    .iss_valid   (iss_valid),
    .iss_area    (iss_area),
    .iss_write   (iss_write),
    .iss_single  (iss_dma_single),
    .prev_valid  (prev_valid),
    .prev_area   (prev_area),
    .prev_write  (prev_write),
    .prev_single (prev_single)
  );

  // R3: with no recorded access the first one goes straight through
  assert_first_free_R3: assert property (@(posedge clk) disable iff (rst)
    (!prev_valid && req_valid && req_ready) |=> iss_valid);

  // R5: a read-to-write turnaround with a nonzero field drops ready
  assert_turnaround_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && prev_valid && prev_area == req_area &&
     !prev_write && req_write && idle_cnt != '0) |=> !req_ready);

endmodule

// File: tb/test_bus_idle_ctrl.sv
module test_bus_idle_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_area = '0;
  logic        req_write = 1'b0;
  logic        req_dma_single = 1'b0;
  logic        req_ready, iss_valid, iss_write, iss_dma_single;
  logic [2:0]  iss_area;

  bus_idle_ctrl i_bus_idle_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_area(req_area), .req_write(req_write),
    .req_dma_single(req_dma_single), .req_ready(req_ready), .iss_valid(iss_valid),
    .iss_area(iss_area), .iss_write(iss_write), .iss_dma_single(iss_dma_single)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [2:0] area;
    logic       wr;
    logic       sg;
    int         cyc;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // Requirement model state
  logic [31:0] m_reg = 32'h7777_7777;
  bit          m_pv = 0;
  logic [2:0]  m_pa = '0;
  logic        m_pw = 1'b0;
  logic        m_ps = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model_idle(logic [2:0] area, logic wr);
    if (!m_pv) return 0;
    if (area != m_pa || (!m_pw && wr)) begin
      if (m_pa == 3'd7) return m_ps ? int'(m_reg[30:28]) : 0;
      return int'(m_reg[int'(m_pa)*4 +: 3]);
    end
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: offer one access, push its predicted issue into the scoreboard
  task automatic do_req(logic [2:0] area, logic wr, logic sg, string req);
    int   c;
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    c = model_idle(area, wr);
    e.area = area; e.wr = wr; e.sg = sg; e.cyc = cyc + 1 + c;
    q.push_back(e);
    m_pv = 1; m_pa = area; m_pw = wr; m_ps = sg;
    req_valid = 1'b1; req_area = area; req_write = wr; req_dma_single = sg;
    @(negedge clk);
    req_valid = 1'b0;
    // R11: ready low exactly when a gap was inserted
    check(req_ready == (c == 0), "R11", {"ready after accept ", req},
          int'(req_ready), int'(c == 0));
  endtask

  task automatic cfg_write(logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m_reg = d & 32'h7777_7777;
  endtask

  // Monitor: compare each issue pulse with the scoreboard head
  always @(negedge clk) begin
    if (!rst && iss_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected issue", int'(iss_area), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(iss_area == e.area && iss_write == e.wr && iss_dma_single == e.sg,
              "R11", "issue attributes", {iss_dma_single, iss_write, iss_area},
              {e.sg, e.wr, e.area});
        check(cyc == e.cyc, "R4", "issue cycle (gap length)", cyc, e.cyc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 32'h7777_7777, "R1", "reset word", cfg_rdata, 32'h7777_7777);
    check(req_ready == 1'b1 && iss_valid == 1'b0, "R1", "reset handshake",
          {req_ready, iss_valid}, 2'b10);

    // R2: reserved bits stay zero, fields take written data
    cfg_write(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h7777_7777, "R2", "all-ones write", cfg_rdata, 32'h7777_7777);
    cfg_write(32'h89AB_CDEF);
    check(cfg_rdata == 32'h0123_4567, "R2", "mixed write", cfg_rdata, 32'h0123_4567);
    repeat (3) @(negedge clk);
    check(cfg_rdata == 32'h0123_4567, "R2", "hold without write", cfg_rdata, 32'h0123_4567);

    // slots 0..6 = 2,3,0,5,1,4,6 ; device = 7
    cfg_write(32'h7641_5032);
    check(cfg_rdata == 32'h7641_5032, "R2", "field layout", cfg_rdata, 32'h7641_5032);

    do_req(3'd0, 1'b0, 1'b0, "R3 first access");
    do_req(3'd0, 1'b0, 1'b0, "R6 read-read");
    do_req(3'd0, 1'b1, 1'b0, "R5 read-write area0 (2)");
    do_req(3'd0, 1'b1, 1'b0, "R6 write-write");
    do_req(3'd0, 1'b0, 1'b0, "R6 write-read");
    do_req(3'd1, 1'b0, 1'b0, "R4 leave area0 (2)");
    do_req(3'd2, 1'b1, 1'b0, "R4 leave area1 (3)");
    do_req(3'd3, 1'b0, 1'b0, "R9 leave area2 (0)");
    do_req(3'd4, 1'b0, 1'b1, "R4 leave area3 (5)");
    do_req(3'd7, 1'b0, 1'b1, "R4 leave area4 (1)");
    do_req(3'd7, 1'b1, 1'b1, "R7 device read-write (7)");
    do_req(3'd5, 1'b0, 1'b1, "R7 leave device (7)");
    do_req(3'd7, 1'b0, 1'b0, "R8 leave area5 (4)");
    do_req(3'd6, 1'b0, 1'b0, "R8 leave code7 dual (0)");
    do_req(3'd1, 1'b1, 1'b0, "R8 dual leave area6 (6)");

    // R10: change area6 mid-countdown; old count must finish
    cfg_write(32'h7741_5032);               // area6 = 7
    do_req(3'd6, 1'b0, 1'b0, "R10 leave area1 (3)");
    do_req(3'd0, 1'b0, 1'b0, "R10 leave area6 (7)");
    cfg_write(32'h7141_5032);               // area6 = 1 while counting
    do_req(3'd6, 1'b0, 1'b0, "R10 leave area0 (2)");
    do_req(3'd2, 1'b0, 1'b0, "R10 leave area6 new (1)");

    // Mixed traffic with occasional reconfiguration
    for (int k = 0; k < 120; k++) begin
      if (($urandom % 10) == 0) cfg_write($urandom);
      do_req(3'($urandom % 8), 1'($urandom), 1'($urandom), "R4 R5 R6 R7 R8 mixed");
    end

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R11", "all accepted accesses issued", q.size(), 0);
    finish_run();
  end

endmodule